// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide programming front end of a three-channel interval timer. A host reaches it through four addresses: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the control port. Control words set up a channel's access type, mode and number format, or freeze values for later reading. Data writes are assembled into counts that are handed to the channel counters. Data reads return either frozen values or the channel's live count.

The counting itself lives outside. The block drives each channel's mode, BCD flag and a one-cycle load strobe with the new count. It receives each channel's live count, its output level, and a strobe that marks when a channel has moved its new count into the counter. A gate register holds each channel's gate level.

Write and read requests are single-cycle strobes. `rdata` is combinational and shows the byte that a read at the current address returns. The read takes effect, and read-side state advances, on the clock edge where `rd_en` is high.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel is idle (`ch_idle` = 3'b111) with access type 1, mode 0 and binary format. Every `ch_count_new` field is 0, `ch_load` is 0, and `ch_gate` = 3'b011 (channels 0 and 1 high, channel 2 low).
- R2: A control-port write with bits 7:6 = channel c (0..2) and bits 5:4 = access (nonzero) programs channel c. Access 1 is low byte only, 2 is high byte only and 3 is low then high. Bits 3:1 give the mode, with codes 6 and 7 stored as 2 and 3. Bit 0 sets BCD. The write also clears `ch_idle[c]`.
- R3: A data write loads a count in one of three ways. Access 1 loads {8'h00, byte}. Access 2 loads {byte, 8'h00}. Access 3 stores the first byte and loads {second, first} on the second byte. `ch_load[c]` pulses for one cycle, in the cycle after the loading write, with the value on `ch_count_new`.
- R4: With nothing frozen, a data read returns the live count: its low byte for access 1, its high byte for access 2, and for access 3 the low and high bytes alternately, starting low.
- R5: A control write with bits 5:4 = 0 freezes the channel's live count. Later reads return the frozen bytes in the programmed order (low then high for access 3). A second freeze before all frozen bytes have been read is ignored.
- R6: A control write with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the count of each selected channel, and bit 4 = 0 freezes its status.
- R7: The status byte is {output level, null-count, access[1:0], mode[2:0], BCD}, with the output level in bit 7 and BCD in bit 0.
- R8: When status and count are both frozen, the first read returns the status byte and the following reads return the frozen count bytes.
- R9: A status freeze is ignored while an earlier frozen status of that channel is unread.
- R10: Read and write byte toggles of access 3 are independent of each other. A control word that programs a channel returns both of its toggles to the low byte.
- R11: A write with `gate_we` high copies `gate_din` into `ch_gate` on the next edge.
- R12: The null-count flag of a channel sets when a count is loaded. It clears when `ch_loaded` for that channel is high and no load happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte returned by a read at `addr` |
| gate_we | input | 1 | Gate register write strobe |
| gate_din | input | 3 | New gate levels, bit c for channel c |
| ch_live_count | input | 48 | Live counts, channel c in bits 16c+15:16c |
| ch_out | input | 3 | Channel output levels |
| ch_loaded | input | 3 | Channel moved its new count into the counter |
| ch_load | output | 3 | One-cycle count load strobe per channel |
| ch_count_new | output | 48 | Count for each channel, channel c in bits 16c+15:16c |
| ch_mode | output | 9 | Mode per channel, channel c in bits 3c+2:3c |
| ch_bcd | output | 3 | BCD format per channel |
| ch_idle | output | 3 | Channel not yet programmed since reset |
| ch_gate | output | 3 | Gate level per channel |

## Verification
The three access types are each driven with distinct byte values, so a swapped byte or a missing shift shows up in the loaded or returned value. The live count is changed between a freeze and its read, which separates frozen data from live data. A repeated freeze with a different live value shows whether the second freeze is wrongly accepted. Read-back commands combine count-only, status-only and both forms over single and multiple channels, which tells apart the selection bits, the read priority, the status encoding and the null-count flag. Reads and writes are interleaved on one channel, and a control word is placed between the two bytes, to separate the two toggles and confirm that reprogramming resets them.

// File: rtl/tmr_regif.sv
module tmr_regif #(
  parameter logic [2:0] GATE_RST = 3'b011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        gate_we,
  input  logic [2:0]  gate_din,
  input  logic [47:0] ch_live_count,
  input  logic [2:0]  ch_out,
  input  logic [2:0]  ch_loaded,
  output logic [2:0]  ch_load,
  output logic [47:0] ch_count_new,
  output logic [8:0]  ch_mode,
  output logic [2:0]  ch_bcd,
  output logic [2:0]  ch_idle,
  output logic [2:0]  ch_gate
);
  localparam int NCH = 3;

  logic       ctl_wr, rb_cmd;
  logic [1:0] sel, acc_f;
  logic [2:0] mode_f;
  logic [NCH-1:0][7:0] rd_byte;

  assign ctl_wr = wr_en && addr == 2'd3;
  assign sel    = wdata[7:6];
  assign acc_f  = wdata[5:4];
  assign rb_cmd = ctl_wr && sel == 2'd3;
  assign mode_f = (wdata[3:2] == 2'b11) ? {1'b0, wdata[2:1]} : wdata[3:1];

  assign rdata = (addr == 2'd3) ? 8'h00 : rd_byte[addr];

  always_ff @(posedge clk) begin
    if (!rst_n)       ch_gate <= GATE_RST;
    else if (gate_we) ch_gate <= gate_din;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0]  acc, cl;
    logic [2:0]  mode;
    logic        bcd, idle, wr_hi, rd_hi, sl, nul, ld;
    logic [7:0]  wl, sv;
    logic [15:0] lv, cnt, live;
    logic        prog, clat, slat, dwr, drd, load_now;
    logic [15:0] load_val;
    logic [7:0]  status;

    assign live = ch_live_count[16*i +: 16];
    assign prog = ctl_wr && sel == 2'(i) && acc_f != 2'd0;
    assign clat = (ctl_wr && sel == 2'(i) && acc_f == 2'd0) ||
                  (rb_cmd && wdata[i+1] && !wdata[5]);
    assign slat = rb_cmd && wdata[i+1] && !wdata[4];
    assign dwr  = wr_en && addr == 2'(i);
    assign drd  = rd_en && addr == 2'(i);
    assign load_now = dwr && (acc != 2'd3 || wr_hi);
    assign status = {ch_out[i], nul, acc, mode, bcd};

    always_comb begin
      case (acc)
        2'd1:    load_val = {8'h00, wdata};
        2'd2:    load_val = {wdata, 8'h00};
        default: load_val = {wdata, wl};
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= 2'd1; mode <= 3'd0; bcd <= 1'b0; idle <= 1'b1;
        wr_hi <= 1'b0; rd_hi <= 1'b0; wl <= 8'h00;
        cl <= 2'd0; lv <= 16'h0; sl <= 1'b0; sv <= 8'h00;
        nul <= 1'b0; cnt <= 16'h0; ld <= 1'b0;
      end else begin
        ld <= load_now;
        if (prog) begin
          acc <= acc_f; mode <= mode_f; bcd <= wdata[0]; idle <= 1'b0;
          wr_hi <= 1'b0; rd_hi <= 1'b0;
        end
        if (clat && cl == 2'd0) begin
          lv <= live;
          cl <= acc;
        end
        if (slat && !sl) begin
          sl <= 1'b1;
          sv <= status;
        end
        if (dwr) begin
          if (acc == 2'd3) wr_hi <= !wr_hi;
          if (acc == 2'd3 && !wr_hi) wl <= wdata;
        end
        if (load_now) cnt <= load_val;
        if (load_now)          nul <= 1'b1;
        else if (ch_loaded[i]) nul <= 1'b0;
        if (drd) begin
          if (sl)                sl <= 1'b0;
          else if (cl != 2'd0)   cl <= (cl == 2'd3) ? 2'd2 : 2'd0;
          else if (acc == 2'd3)  rd_hi <= !rd_hi;
        end
      end
    end

    always_comb begin
      if (sl)                               rd_byte[i] = sv;
      else if (cl == 2'd1 || cl == 2'd3)    rd_byte[i] = lv[7:0];
      else if (cl == 2'd2)                  rd_byte[i] = lv[15:8];
      else if (acc == 2'd2 || (acc == 2'd3 && rd_hi)) rd_byte[i] = live[15:8];
      else                                  rd_byte[i] = live[7:0];
    end

    assign ch_load[i]              = ld;
    assign ch_count_new[16*i +: 16] = cnt;
    assign ch_mode[3*i +: 3]        = mode;
    assign ch_bcd[i]               = bcd;
    assign ch_idle[i]              = idle;
  end
endmodule

module tmr_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic        gate_we,
  input logic [2:0]  gate_din,
  input logic [2:0]  ch_load,
  input logic [47:0] ch_count_new,
  input logic [8:0]  ch_mode,
  input logic [2:0]  ch_bcd,
  input logic [2:0]  ch_idle,
  input logic [2:0]  ch_gate
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ch_idle == 3'b111 && ch_load == 3'b000 && ch_count_new == 48'h0); // R1

  AST_LOAD_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load != 3'b000) |-> $past(wr_en) && $past(addr) != 2'd3); // R3

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load)); // R3

  AST_COUNT_CHANGES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_count_new) |-> ch_load != 3'b000); // R3

  AST_GATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_we |=> ch_gate == $past(gate_din)); // R11

  for (genvar i = 0; i < 3; i++) begin : g_a
    AST_PROGRAM_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
      |=> !ch_idle[i] && ch_bcd[i] == $past(wdata[0])); // R2
    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[3*i +: 3] <= 3'd5); // R2
  end
endmodule

bind tmr_regif tmr_regif_chk u_chk (.*);

// File: tb/tmr_regif_tb_top.sv
module tmr_regif_tb_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, rd_en = 0, gate_we = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [2:0]  gate_din = 0, ch_out = 3'b101, ch_loaded = 0;
  logic [47:0] ch_live_count = {16'h5A0F, 16'hABCD, 16'h1234};
  logic [2:0]  ch_load, ch_bcd, ch_idle, ch_gate;
  logic [47:0] ch_count_new;
  logic [8:0]  ch_mode;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #(CLK_PER/2) clk = ~clk;

  tmr_regif dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
    #1;
  endtask

  always @(negedge clk) begin
    #2;
    if (rd_en) begin
      if (exp_q.size() == 0) check("read without expectation", rdata, 8'hxx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 idle", ch_idle, 3'b111);
    check("R1 gate", ch_gate, 3'b011);
    check("R1 count", ch_count_new, 48'h0);
    check("R1 mode", ch_mode, 9'h0);
    check("R1 load", ch_load, 3'b000);

    wr(3, 8'h34);
    check("R2 mode ch0", ch_mode[2:0], 3'd2);
    check("R2 idle ch0", ch_idle[0], 1'b0);
    wr(0, 8'h78);
    check("R3 no load after low byte", ch_load, 3'b000);
    wr(0, 8'h56);
    check("R3 load word", ch_load, 3'b001);
    check("R3 word value", ch_count_new[15:0], 16'h5678);
    rd(0, 8'h34, "R4 word low");
    rd(0, 8'h12, "R4 word high");

    wr(3, 8'h6F);
    check("R2 mode 7 as 3", ch_mode[5:3], 3'd3);
    check("R2 bcd ch1", ch_bcd[1], 1'b1);
    wr(1, 8'h22);
    check("R3 msb-only load", ch_load, 3'b010);
    check("R3 msb-only value", ch_count_new[31:16], 16'h2200);
    rd(1, 8'hAB, "R4 msb only");
    rd(1, 8'hAB, "R4 msb only repeat");

    wr(3, 8'h9C);
    check("R2 mode 6 as 2", ch_mode[8:6], 3'd2);
    wr(2, 8'h09);
    check("R3 lsb-only value", ch_count_new[47:32], 16'h0009);
    rd(2, 8'h0F, "R4 lsb only");

    wr(3, 8'h00);
    ch_live_count[15:0] = 16'h4321;
    rd(0, 8'h34, "R5 frozen low");
    rd(0, 8'h12, "R5 frozen high");
    rd(0, 8'h21, "R5 live after frozen");
    rd(0, 8'h43, "R4 live high");

    wr(3, 8'h40);
    ch_live_count[31:16] = 16'h1111;
    wr(3, 8'h40);
    rd(1, 8'hAB, "R5 second freeze ignored");
    rd(1, 8'h11, "R5 live after freeze");

    wr(3, 8'hC2);
    rd(0, 8'hF4, "R8 status first");
    rd(0, 8'h21, "R8 count low after status");
    rd(0, 8'h43, "R8 count high");
    rd(0, 8'h21, "R6 live low");
    @(negedge clk); ch_loaded = 3'b001;
    @(negedge clk); ch_loaded = 3'b000;
    wr(3, 8'hE2);
    rd(0, 8'hB4, "R12 null cleared in status");
    rd(0, 8'h43, "R6 status-only leaves count live");

    wr(3, 8'hE8);
    ch_out = 3'b001;
    wr(3, 8'hE8);
    rd(2, 8'hD4, "R9 status freeze ignored");
    rd(2, 8'h0F, "R7 live after status");

    rd(0, 8'h21, "R10 read toggle low");
    wr(0, 8'hAA);
    wr(3, 8'h34);
    rd(0, 8'h21, "R10 control resets read toggle");
    wr(0, 8'h11);
    check("R10 control resets write toggle", ch_load, 3'b000);
    rd(0, 8'h43, "R10 read toggle independent");
    wr(0, 8'h22);
    check("R10 word load", ch_count_new[15:0], 16'h2211);

    @(negedge clk); gate_we = 1; gate_din = 3'b100;
    @(negedge clk); gate_we = 0;
    #1;
    check("R11 gate", ch_gate, 3'b100);

    ch_live_count[47:32] = 16'h7777;
    wr(3, 8'hDC);
    ch_live_count[47:32] = 16'h0000;
    rd(2, 8'h77, "R6 multi-channel frozen ch2");
    rd(1, 8'h11, "R6 multi-channel frozen ch1");
    rd(2, 8'h00, "R6 ch2 live after");

    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule